// File: doc/BRIEF.md
# Standby-Spare Selection Switch

This block puts one of N identical processing units in front of the rest of the system and replaces it when it is found faulty. Every unit delivers a data word on a shared valid/ready stream edge and has its own fault line, driven by an outside detector such as a code checker, a plausibility check or an expired watchdog. The switch routes the word of the current primary unit to its output. When that unit's detector fires, the switch marks the unit faulty for good and moves to the lowest-numbered unit that is still healthy. A power-enable line per unit lets spares stay powered down (cold standby) until they are chosen.

A build-time parameter selects duplex operation. In that mode two healthy units run together and their words are compared. A fault on either unit, or a difference between the two words on an accepted transfer, retires both units. The next two healthy units then take over. When the switch runs out of healthy units it raises an exhausted flag and keeps its last selection.

The stream path holds no storage. `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`, in the same cycle. Back-pressure from downstream therefore stalls all units at once. The switchover takes effect on the clock edge at which the fault is sampled.

Top module: `spare_switch`

## Requirements
- R1: After reset, unit 0 is primary (in duplex mode units 0 and 1 form the pair, unit 1 on `second_idx`), the faulty mask is all zero and `exhausted` is 0.
- R2: `out_data` equals the word of unit `primary_idx`, taken from bits [i*DATA_W +: DATA_W] of `unit_data`. `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle.
- R3: In simplex mode, a fault on the primary unit, sampled at a clock edge, has these effects from that edge on: the unit's bit is set in `faulty_mask`, and the lowest-index unit not flagged becomes primary.
- R4: Fault lines of units that are not currently selected change neither `faulty_mask` nor the selection.
- R5: Bits of `faulty_mask` never clear before reset, and `primary_idx` never decreases.
- R6: When a unit is retired and too few healthy units remain, the retired units are still flagged and `exhausted` is set. The selection is kept, and later faults change nothing.
- R7: In duplex mode the pair is the two lowest healthy units: `primary_idx` is the lower one and `second_idx` the higher one. `out_data` comes from the lower one.
- R8: In duplex mode, a fault on either unit of the pair retires both units at the next edge. A difference between the two words while `in_valid` is 1 also retires both. A difference while `in_valid` is 0 is ignored.
- R9: In duplex mode, `exhausted` is set when fewer than two healthy units remain after a retirement.
- R10: `power_en` has bit i set exactly for the units that are currently selected. All other spares stay unpowered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_data | input | N_UNITS*DATA_W | Packed words of all units, unit i at [i*DATA_W +: DATA_W] |
| in_valid | input | 1 | Units present a word |
| in_ready | output | 1 | Word accepted (follows out_ready) |
| unit_fault | input | N_UNITS | Per-unit detector outputs |
| out_data | output | DATA_W | Word of the primary unit |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream can take the word |
| primary_idx | output | IDX_W | Index of the primary unit |
| second_idx | output | IDX_W | Partner unit in duplex mode, equal to primary_idx in simplex mode |
| faulty_mask | output | N_UNITS | Units flagged faulty |
| exhausted | output | 1 | No healthy replacement was left |
| power_en | output | N_UNITS | Power enable for selected units |

## Verification
A pseudo-random sweep drives fault vectors of three kinds. Vectors that hit the primary unit test the advance to the next healthy unit. Vectors that touch only idle units must leave the state alone. Repeated hits run the switch through to exhaustion, which shows that the flags are sticky and the selection is held. In duplex mode, word differences are injected with `in_valid` both high and low. This shows that a comparison only counts on a valid transfer. It also shows that a fault on the partner unit retires the pair in the same way as a fault on the lower unit. `out_ready` is toggled throughout to show that the ready path passes through unchanged.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic {SEL_SIMPLEX = 1'b0, SEL_DUPLEX = 1'b1} sel_mode_e;
endpackage

// File: rtl/sw_pick.sv
// Finds the lowest and second-lowest set bits of a candidate mask.
module sw_pick #(
  parameter int N_UNITS = 4,
  localparam int IDX_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic [N_UNITS-1:0] cand,
  output logic [IDX_W-1:0]   first_idx,
  output logic [IDX_W-1:0]   second_idx,
  output logic               have_one,
  output logic               have_two
);
  always_comb begin
    first_idx  = '0;
    second_idx = '0;
    have_one   = 1'b0;
    have_two   = 1'b0;
    for (int i = 0; i < N_UNITS; i++) begin
      if (cand[i]) begin
        if (!have_one) begin
          first_idx = IDX_W'(i);
          have_one  = 1'b1;
        end else if (!have_two) begin
          second_idx = IDX_W'(i);
          have_two   = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sw_mux.sv
// Selects one unit word out of the packed bus.
module sw_mux #(
  parameter int N_UNITS = 4,
  parameter int DATA_W  = 8,
  localparam int IDX_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic [N_UNITS*DATA_W-1:0] bus,
  input  logic [IDX_W-1:0]          sel,
  output logic [DATA_W-1:0]         word
);
  always_comb begin
    word = '0;
    for (int i = 0; i < N_UNITS; i++) begin
      if (sel == IDX_W'(i)) word = bus[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/spare_switch.sv
module spare_switch
  import sw_pkg::*;
#(
  parameter int        N_UNITS = 4,
  parameter int        DATA_W  = 8,
  parameter sel_mode_e MODE    = SEL_SIMPLEX,
  localparam int IDX_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_UNITS*DATA_W-1:0] unit_data,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [N_UNITS-1:0]        unit_fault,
  output logic [DATA_W-1:0]         out_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [IDX_W-1:0]          primary_idx,
  output logic [IDX_W-1:0]          second_idx,
  output logic [N_UNITS-1:0]        faulty_mask,
  output logic                      exhausted,
  output logic [N_UNITS-1:0]        power_en
);
  localparam bit DUPLEX = (MODE == SEL_DUPLEX);

  logic [IDX_W-1:0]   pri_q, sec_q;
  logic [N_UNITS-1:0] mask_q;
  logic               ex_q;

  logic               trip;
  logic [N_UNITS-1:0] retire;
  logic [N_UNITS-1:0] pri_oh, sec_oh;
  logic [IDX_W-1:0]   nxt_first, nxt_second;
  logic               have_one, have_two, enough;

  always_comb begin
    pri_oh = '0;
    sec_oh = '0;
    pri_oh[pri_q] = 1'b1;
    sec_oh[sec_q] = 1'b1;
  end

  // Stream edge: no storage, ready and valid pass straight through.
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  sw_mux #(.N_UNITS(N_UNITS), .DATA_W(DATA_W)) u_pri_mux (
    .bus(unit_data), .sel(pri_q), .word(out_data)
  );

  generate
    if (DUPLEX) begin : g_duplex
      logic [DATA_W-1:0] sec_word;
      sw_mux #(.N_UNITS(N_UNITS), .DATA_W(DATA_W)) u_sec_mux (
        .bus(unit_data), .sel(sec_q), .word(sec_word)
      );
      assign trip   = !ex_q && (unit_fault[pri_q] || unit_fault[sec_q] ||
                                (in_valid && (sec_word != out_data)));
      assign retire = pri_oh | sec_oh;
      assign enough = have_two;
    end else begin : g_simplex
      assign trip   = !ex_q && unit_fault[pri_q];
      assign retire = pri_oh;
      assign enough = have_one;
    end
  endgenerate

  sw_pick #(.N_UNITS(N_UNITS)) u_pick (
    .cand      (~(mask_q | retire)),
    .first_idx (nxt_first),
    .second_idx(nxt_second),
    .have_one  (have_one),
    .have_two  (have_two)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pri_q  <= '0;
      sec_q  <= DUPLEX ? IDX_W'(1) : '0;
      mask_q <= '0;
      ex_q   <= 1'b0;
    end else if (trip) begin
      mask_q <= mask_q | retire;
      if (enough) begin
        pri_q <= nxt_first;
        sec_q <= DUPLEX ? nxt_second : nxt_first;
      end else begin
        ex_q <= 1'b1;
      end
    end
  end

  assign primary_idx = pri_q;
  assign second_idx  = sec_q;
  assign faulty_mask = mask_q;
  assign exhausted   = ex_q;
  assign power_en    = pri_oh | sec_oh;

  // R3: while not exhausted the primary unit is never a flagged one
  p_primary_healthy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_q |-> !mask_q[pri_q]);

  // R5: flags are sticky
  p_mask_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q & $past(mask_q)) == $past(mask_q)));

  // R5: primary index only moves upward
  p_ascend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_q >= $past(pri_q)));

  // R6: once exhausted, nothing moves
  p_exhaust_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ex_q |=> (ex_q && $stable(pri_q) && $stable(sec_q) && $stable(mask_q)));

  // R3: a fault on the primary flags that unit at the next edge
  p_flag_primary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_q && unit_fault[pri_q]) |=> mask_q[$past(pri_q)]);

  // R4: a state change only happens when a selected unit tripped
  p_idle_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip) |=> ($stable(mask_q) && $stable(pri_q)));

  // R10: power goes only to the selected units
  p_power_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(power_en) == (DUPLEX ? 2 : 1)));
endmodule

// File: tb/test_spare_switch.sv
module test_spare_switch;
  import sw_pkg::*;

  localparam int NS = 4, NP = 5, W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // simplex instance
  logic [NS*W-1:0] data_s;
  logic [NS-1:0]   fault_s;
  logic            vin_s, rdy;
  logic            in_ready_s, out_valid_s, ex_s;
  logic [W-1:0]    out_s;
  logic [1:0]      pri_s, sec_s;
  logic [NS-1:0]   mask_s, pwr_s;

  // duplex instance
  logic [NP*W-1:0] data_p;
  logic [NP-1:0]   fault_p;
  logic            vin_p;
  logic            in_ready_p, out_valid_p, ex_p;
  logic [W-1:0]    out_p;
  logic [2:0]      pri_p, sec_p;
  logic [NP-1:0]   mask_p, pwr_p;

  spare_switch #(.N_UNITS(NS), .DATA_W(W), .MODE(SEL_SIMPLEX)) i_spare_switch (
    .clk(clk), .rst_n(rst_n), .unit_data(data_s), .in_valid(vin_s),
    .in_ready(in_ready_s), .unit_fault(fault_s), .out_data(out_s),
    .out_valid(out_valid_s), .out_ready(rdy), .primary_idx(pri_s),
    .second_idx(sec_s), .faulty_mask(mask_s), .exhausted(ex_s), .power_en(pwr_s)
  );

  spare_switch #(.N_UNITS(NP), .DATA_W(W), .MODE(SEL_DUPLEX)) i_spare_switch_pair (
    .clk(clk), .rst_n(rst_n), .unit_data(data_p), .in_valid(vin_p),
    .in_ready(in_ready_p), .unit_fault(fault_p), .out_data(out_p),
    .out_valid(out_valid_p), .out_ready(rdy), .primary_idx(pri_p),
    .second_idx(sec_p), .faulty_mask(mask_p), .exhausted(ex_p), .power_en(pwr_p)
  );

  int errors = 0, checks = 0;
  int m_pri_s, m_mask_s, m_ex_s;
  int m_a, m_b, m_mask_p, m_ex_p;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lowest_free(input int mask, input int n, input int skip);
    for (int i = 0; i < n; i++)
      if (!mask[i] && i != skip) return i;
    return -1;
  endfunction

  task automatic check_state();
    chk("R3 primary", int'(pri_s), m_pri_s);
    chk("R5 mask", int'(mask_s), m_mask_s);
    chk("R6 exhausted", int'(ex_s), m_ex_s);
    chk("R10 power", int'(pwr_s), 1 << m_pri_s);
    chk("R7 primary", int'(pri_p), m_a);
    chk("R7 second", int'(sec_p), m_b);
    chk("R8 mask", int'(mask_p), m_mask_p);
    chk("R9 exhausted", int'(ex_p), m_ex_p);
    chk("R10 pair power", int'(pwr_p), (1 << m_a) | (1 << m_b));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fault_s = '0; fault_p = '0; vin_s = 1'b0; vin_p = 1'b0; rdy = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_pri_s = 0; m_mask_s = 0; m_ex_s = 0;
    m_a = 0; m_b = 1; m_mask_p = 0; m_ex_p = 0;
    chk("R1 primary", int'(pri_s), 0);
    chk("R1 second", int'(sec_p), 1);
    chk("R1 mask", int'(mask_s) + int'(mask_p), 0);
    chk("R1 exhausted", int'(ex_s) + int'(ex_p), 0);
  endtask

  task automatic step(input logic [NS-1:0] fs, input logic [NP-1:0] fp,
                      input logic bad, input logic vp, input logic r, input int n);
    logic [W-1:0] base;
    logic         trip_s, trip_p, hit;
    int           f1, f2, nm;
    @(negedge clk);
    base = W'(8'hA0 ^ n);
    for (int i = 0; i < NS; i++) data_s[i*W +: W] = {4'(i), 4'(n)};
    for (int i = 0; i < NP; i++) data_p[i*W +: W] = base;
    if (bad) data_p[m_b*W +: W] = base ^ 8'h01;
    fault_s = fs; fault_p = fp; vin_s = 1'b1; vin_p = vp; rdy = r;
    #1;
    chk("R2 data", int'(out_s), int'({4'(m_pri_s), 4'(n)}));
    chk("R2 ready", int'(in_ready_s), int'(r));
    chk("R2 valid", int'(out_valid_p), int'(vp));
    chk("R7 data", int'(out_p), int'(base));
    // reference update
    trip_s = (m_ex_s == 0) && fs[m_pri_s];
    if (trip_s) begin
      m_mask_s = m_mask_s | (1 << m_pri_s);
      f1 = lowest_free(m_mask_s, NS, -1);
      if (f1 < 0) m_ex_s = 1; else m_pri_s = f1;
    end
    hit = fp[m_a] || fp[m_b] || (vp && bad);
    trip_p = (m_ex_p == 0) && hit;
    if (trip_p) begin
      nm = m_mask_p | (1 << m_a) | (1 << m_b);
      m_mask_p = nm;
      f1 = lowest_free(nm, NP, -1);
      f2 = (f1 < 0) ? -1 : lowest_free(nm, NP, f1);
      if (f2 < 0) m_ex_p = 1; else begin m_a = f1; m_b = f2; end
    end
    @(posedge clk);
    #2;
    if (!trip_s && fs != 0) chk("R4 idle faults", int'(mask_s), m_mask_s);
    if (bad && !vp) chk("R8 mismatch without valid", int'(mask_p), m_mask_p);
    check_state();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [NS-1:0] fs;
    logic [NP-1:0] fp;
    do_reset();
    for (int n = 0; n < 600; n++) begin
      if (n % 12 == 11) do_reset();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fs = NS'(lfsr[3:0]);
      if (!lfsr[4]) fs[m_pri_s] = 1'b0;   // idle-only pattern
      fp = NP'(lfsr[8:4]);
      if (!lfsr[9]) begin fp[m_a] = 1'b0; fp[m_b] = 1'b0; end
      step(fs, fp, lfsr[10] & lfsr[11], lfsr[12], lfsr[13], n);
    end
    // directed: run simplex to exhaustion and keep faulting (R6)
    do_reset();
    for (int k = 0; k < NS + 2; k++)
      step(NS'(1) << m_pri_s, '0, 1'b0, 1'b1, 1'b1, k);
    chk("R6 held primary", int'(pri_s), NS - 1);
    chk("R6 all flagged", int'(mask_s), (1 << NS) - 1);
    // directed: duplex mismatch walk to exhaustion (R8, R9)
    do_reset();
    for (int k = 0; k < 4; k++) step('0, '0, 1'b1, 1'b1, 1'b1, k);
    chk("R9 pair exhausted", int'(ex_p), 1);
    chk("R9 pair kept", int'(pri_p), 2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule